// File: doc/BRIEF.md
# Pixel Colour Component Extractor

This block sits between a framebuffer fetch path and a display output stage. It takes a raw pixel word and produces an 8-bit red, green and blue value. Software programs the pixel width in bytes and, for each colour channel, where the channel's field starts in the word, how many bits wide it is, and a substitute value. The extracted field is left-aligned into the 8-bit output byte.

The substitute value replaces the extracted field in three cases: the pixel lies outside the visible area, the fetch path reports an underrun, or the channel's field length is programmed to zero. A typical use is to set a saturated red substitute so that underruns stand out on screen. The outputs are registered, and a valid flag travels with the data.

Top module: `pix_comp_extract`

## Requirements
- R1: After reset, `out_valid` is low, all three colour outputs are 0, the pixel width is one byte, and every channel has field length 0 and substitute value 0.
- R2: A write with `cfg_addr`=0 sets the pixel width in bytes minus one from `cfg_wdata[4:3]`. A write with `cfg_addr`=1, 2 or 3 programs red, green or blue: substitute value in bits 23:16, field length in bits 11:8, lowest bit index in bits 4:0. The new setting applies to pixels captured on later clock edges.
- R3: Bytes of `pix_data` above the programmed pixel width read as zero before extraction.
- R4: With a nonzero length L and a start position P, the field is bits P to P+L-1 of the masked word, and bit positions above 31 read as zero.
- R5: A field shorter than 8 bits appears in the top L bits of the output, and the lower bits are zero.
- R6: A field longer than 8 bits is reduced to its top 8 bits.
- R7: A channel with field length 0 outputs its substitute value.
- R8: When `pix_visible` is low, every channel outputs its substitute value.
- R9: When `pix_underrun` is high, every channel outputs its substitute value.
- R10: Outputs reflect the pixel captured at the previous rising edge, and `out_valid` equals `pix_valid` delayed by one cycle.
- R11: While `pix_valid` is low, the colour outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| pix_data | input | 32 | Raw pixel word |
| pix_valid | input | 1 | Pixel word is present |
| pix_visible | input | 1 | Pixel lies in the visible area |
| pix_underrun | input | 1 | Fetch path underrun |
| out_r | output | 8 | Red component |
| out_g | output | 8 | Green component |
| out_b | output | 8 | Blue component |
| out_valid | output | 1 | Component outputs are valid |

## Verification
Directed cases place a field near the top of the word so that it runs past bit 31, shrink the pixel width so that a field falls into masked bytes, and use lengths of 3, 8 and 12, which separate zero fill, exact fit and truncation. Random words are then run under random channel settings, with blanking and underrun mixed in, so that the substitute path can be told apart from extraction of a field whose value happens to be the same. Idle cycles with changing data show whether the outputs hold. Register writes placed between pixels show whether a new setting takes effect on the following pixel.

// File: rtl/pce_pkg.sv
package pce_pkg;
  parameter int PIX_BYTES = 4;
  parameter int COMP_W    = 8;
  parameter int LEN_W     = 4;
  parameter int NUM_CH    = 3;

  localparam int PIX_W = PIX_BYTES * 8;
  localparam int POS_W = $clog2(PIX_W);
  localparam int BPP_W = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1;

  // Field positions in the configuration words (software decodes these)
  localparam int FMT_LSB   = 3;
  localparam int DFLT_LSB  = 16;
  localparam int LEN_LSB   = 8;
  localparam int POS_LSB   = 0;

  typedef struct packed {
    logic [COMP_W-1:0] dflt;
    logic [LEN_W-1:0]  len;
    logic [POS_W-1:0]  pos;
  } ch_sel_t;

  // Keep only the bytes inside the programmed pixel width
  function automatic logic [PIX_W-1:0] width_mask(input logic [PIX_W-1:0] w,
                                                  input logic [BPP_W-1:0] nb_m1);
    logic [PIX_W-1:0] m;
    for (int b = 0; b < PIX_BYTES; b++) begin
      m[b*8 +: 8] = (b <= int'(nb_m1)) ? 8'hFF : 8'h00;
    end
    return w & m;
  endfunction

  // Pull out a field and left-align it into the component byte
  function automatic logic [COMP_W-1:0] align_field(input logic [PIX_W-1:0] w,
                                                    input logic [POS_W-1:0] pos,
                                                    input logic [LEN_W-1:0] len);
    logic [PIX_W-1:0] shifted;
    logic [PIX_W-1:0] lmask;
    logic [PIX_W-1:0] field;
    logic [PIX_W-1:0] placed;
    shifted = w >> pos;
    lmask   = (PIX_W'(1) << len) - PIX_W'(1);
    field   = shifted & lmask;
    if (int'(len) >= COMP_W)
      placed = field >> (int'(len) - COMP_W);
    else
      placed = field << (COMP_W - int'(len));
    return placed[COMP_W-1:0];
  endfunction
endpackage

// File: rtl/pce_cfg_regs.sv
module pce_cfg_regs
  import pce_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [1:0]             cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [BPP_W-1:0]       nb_m1,
  output ch_sel_t [NUM_CH-1:0]   sel
);
  logic fmt_hit;
  logic [NUM_CH-1:0] ch_hit;

  assign fmt_hit = cfg_wr && (cfg_addr == 2'd0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign ch_hit[c] = cfg_wr && (int'(cfg_addr) == c + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_m1 <= '0;
    end else if (fmt_hit) begin
      nb_m1 <= cfg_wdata[FMT_LSB +: BPP_W];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel[c] <= '0;
      end else if (ch_hit[c]) begin
        sel[c].dflt <= cfg_wdata[DFLT_LSB +: COMP_W];
        sel[c].len  <= cfg_wdata[LEN_LSB +: LEN_W];
        sel[c].pos  <= cfg_wdata[POS_LSB +: POS_W];
      end
    end

    // R2: a channel write lands in that channel's settings
    p_chwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ch_hit[c] |=> (sel[c].len == $past(cfg_wdata[LEN_LSB +: LEN_W]))
                 && (sel[c].dflt == $past(cfg_wdata[DFLT_LSB +: COMP_W])));
  end

  // R2: a format write lands in the width field
  p_fmtwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_hit |=> nb_m1 == $past(cfg_wdata[FMT_LSB +: BPP_W]));

  // R2: with no write the settings do not move
  p_cfg_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(nb_m1) && $stable(sel));
endmodule

// File: rtl/pce_channel.sv
module pce_channel
  import pce_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PIX_W-1:0]    word,
  input  logic                take,
  input  logic                blank,
  input  ch_sel_t             sel,
  output logic [COMP_W-1:0]   comp
);
  logic               len_zero;
  logic               use_dflt;
  logic [COMP_W-1:0]  extracted;
  logic [COMP_W-1:0]  comp_d;

  assign len_zero  = (sel.len == '0);
  assign use_dflt  = blank || len_zero;
  assign extracted = align_field(word, sel.pos, sel.len);
  assign comp_d    = use_dflt ? sel.dflt : extracted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    comp <= '0;
    else if (take) comp <= comp_d;
  end

  // R8 / R9: blanking or underrun yields the substitute value
  p_blank_dflt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && blank |=> comp == $past(sel.dflt));

  // R7: zero-length field yields the substitute value
  p_len0_dflt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && len_zero |=> comp == $past(sel.dflt));

  // R11: idle cycles leave the component untouched
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(comp));

  // R5: short fields leave the low bits clear
  p_lowfill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !use_dflt && (sel.len == LEN_W'(1)) |=> comp[COMP_W-2:0] == '0);
endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract
  import pce_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [1:0]   cfg_addr,
  input  logic [31:0]  cfg_wdata,
  input  logic [31:0]  pix_data,
  input  logic         pix_valid,
  input  logic         pix_visible,
  input  logic         pix_underrun,
  output logic [7:0]   out_r,
  output logic [7:0]   out_g,
  output logic [7:0]   out_b,
  output logic         out_valid
);
  logic [BPP_W-1:0]        nb_m1;
  ch_sel_t [NUM_CH-1:0]    sel;
  logic [PIX_W-1:0]        word_m;
  logic                    blank_evt;
  logic [NUM_CH-1:0][COMP_W-1:0] comp;

  pce_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .nb_m1     (nb_m1),
    .sel       (sel)
  );

  assign word_m    = width_mask(pix_data[PIX_W-1:0], nb_m1);
  assign blank_evt = !pix_visible || pix_underrun;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pce_channel u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .word  (word_m),
      .take  (pix_valid),
      .blank (blank_evt),
      .sel   (sel[c]),
      .comp  (comp[c])
    );

    // R3: a field lying wholly in masked bytes extracts as zero
    p_masked_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && !blank_evt && (sel[c].len != '0)
      && (int'(sel[c].pos) >= 8 * (int'(nb_m1) + 1)) |=> comp[c] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= pix_valid;
  end

  assign out_r = comp[0];
  assign out_g = comp[1];
  assign out_b = comp[2];

  // R10: valid flag follows the input one cycle later
  p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  p_invalid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
endmodule

// File: tb/pix_comp_extract_bench.sv
module pix_comp_extract_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pix_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_visible = 1'b0;
  logic        pix_underrun = 1'b0;
  logic [7:0]  out_r, out_g, out_b;
  logic        out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] sh_fmt;
  logic [31:0] sh_sel [3];
  logic [7:0]  last [3];

  always #10 clk = ~clk;

  pix_comp_extract u_pix_comp_extract (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_visible(pix_visible), .pix_underrun(pix_underrun),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_valid(out_valid)
  );

  // Bit-by-bit reference built from the requirement text
  function automatic logic [7:0] model(input logic [31:0] w, input logic [31:0] fmt,
                                      input logic [31:0] s, input logic vis, input logic und);
    int nbits = (int'(fmt[4:3]) + 1) * 8;
    int len   = int'(s[11:8]);
    int pos   = int'(s[4:0]);
    logic [15:0] f = '0;
    logic [7:0]  o = '0;
    if (!vis || und || len == 0) return s[23:16];
    for (int i = 0; i < len; i++) begin
      int idx = pos + i;
      f[i] = (idx < 32 && idx < nbits) ? w[idx] : 1'b0;
    end
    for (int k = 0; k < 8; k++) begin
      int src = len - 1 - k;
      o[7-k] = (src >= 0) ? f[src] : 1'b0;
    end
    return o;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a == 2'd0) sh_fmt = d; else sh_sel[int'(a)-1] = d;
  endtask

  task automatic px(input string req, input logic [31:0] w, input logic v,
                    input logic vis, input logic und);
    logic [7:0] e [3];
    @(negedge clk);
    pix_data = w; pix_valid = v; pix_visible = vis; pix_underrun = und;
    for (int c = 0; c < 3; c++)
      e[c] = v ? model(w, sh_fmt, sh_sel[c], vis, und) : last[c];
    @(posedge clk);
    #2;
    chk({req, " red"},   {24'h0, out_r}, {24'h0, e[0]});
    chk({req, " green"}, {24'h0, out_g}, {24'h0, e[1]});
    chk({req, " blue"},  {24'h0, out_b}, {24'h0, e[2]});
    chk("R10 valid", {31'h0, out_valid}, {31'h0, v});
    for (int c = 0; c < 3; c++) last[c] = e[c];
    pix_valid = 1'b0;
  endtask

  function automatic logic [31:0] mksel(input logic [7:0] d, input logic [3:0] l,
                                        input logic [4:0] p);
    return {8'h0, d, 4'h0, l, 3'h0, p};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    sh_fmt = '0;
    for (int c = 0; c < 3; c++) begin sh_sel[c] = '0; last[c] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'h0, out_valid}, 32'h0);
    chk("R1 red", {24'h0, out_r}, 32'h0);
    chk("R1 blue", {24'h0, out_b}, 32'h0);
    rst_n = 1'b1;
    // R1: reset config gives zero-length channels with zero substitute
    px("R1 cfg", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);

    // R2 / R4 / R5: 32-bit pixel, red 8b@16, green 3b@8, blue 8b@0
    wr(2'd0, 32'h3 << 3);
    wr(2'd1, mksel(8'hFF, 4'd8, 5'd16));
    wr(2'd2, mksel(8'h11, 4'd3, 5'd8));
    wr(2'd3, mksel(8'h22, 4'd8, 5'd0));
    px("R4 R5 basic", 32'h00A5_05C3, 1'b1, 1'b1, 1'b0);
    // R9: underrun shows substitute (red saturated)
    px("R9 underrun", 32'h1234_5678, 1'b1, 1'b1, 1'b1);
    // R8: outside visible area
    px("R8 blank", 32'h1234_5678, 1'b1, 1'b0, 1'b0);
    // R11: idle cycle with new data holds outputs
    px("R11 hold", 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0);
    // R6: 12-bit field truncated to its top 8 bits
    wr(2'd1, mksel(8'h00, 4'd12, 5'd4));
    px("R6 trunc", 32'h0000_ABC0, 1'b1, 1'b1, 1'b0);
    // R4: field running past bit 31
    wr(2'd2, mksel(8'h00, 4'd8, 5'd28));
    px("R4 top edge", 32'hF000_0000, 1'b1, 1'b1, 1'b0);
    // R7: zero length yields substitute
    wr(2'd3, mksel(8'h5A, 4'd0, 5'd0));
    px("R7 len0", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
    // R3: one-byte pixel masks upper bytes
    wr(2'd0, 32'h0);
    wr(2'd1, mksel(8'h00, 4'd8, 5'd4));
    px("R3 mask 1B", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
    // R3: two-byte pixel
    wr(2'd0, 32'h1 << 3);
    px("R3 mask 2B", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [31:0] w;
      logic vis, und, v;
      string tag;
      if (it % 25 == 0) begin
        wr(2'd0, {27'h0, 2'($urandom_range(0, 3)), 3'h0} | ($urandom & 32'hFFFF_FFE7));
        for (int c = 0; c < 3; c++)
          wr(2'(c + 1), $urandom);
      end
      w   = $urandom;
      vis = ($urandom_range(0, 7) != 0);
      und = ($urandom_range(0, 9) == 0);
      v   = ($urandom_range(0, 5) != 0);
      if (!v)       tag = "R11 rand";
      else if (!vis) tag = "R8 rand";
      else if (und)  tag = "R9 rand";
      else           tag = "R4 rand";
      px(tag, w, v, vis, und);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule